// File: doc/BRIEF.md
# Unaligned 8x8 Reference Block Fetch

This block returns one 8x8 block of reference samples per clock, starting at any integer position inside a stored search area. The search area is spread over 64 memory banks that form an 8x8 grid: the sample at coordinate (x, y) lives in bank (x mod 8, y mod 8). Each bank therefore holds one sample out of every eight in each direction. Any 8x8 window, aligned or not, touches every bank exactly once, so all 64 samples of the window can be read in parallel.

A request gives a block origin and a signed integer motion vector; the start position is their sum. Each bank gets its own read address. When a bank's column index is below the horizontal offset within a tile, that bank reads from the next tile column. The same rule applies vertically, using the row index. The 64 returned samples are then rotated horizontally and vertically so that the output is in raster order. Requests may arrive back to back, in any order. A start position outside the stored area is clamped to the nearest legal window, and the result is flagged. A separate single-sample write port fills the banks.

Top module: `ref_blk_fetch`

## Requirements
- R1: A sample written at coordinate (x, y) is stored in bank (x mod 8, y mod 8) and is returned by every later read whose window covers (x, y).
- R2: A read whose start position is a multiple of 8 in both axes returns the tile at that position.
- R3: A read at any unaligned start position returns the correct 8x8 window, including windows that span four tiles.
- R4: out_valid rises exactly two clock edges after a clock edge that samples rd_en high, and stays low two edges after an edge that samples rd_en low.
- R5: A new read can be accepted on every clock, with start positions in any order. Each read produces its own result, in the order the reads were issued.
- R6: A start coordinate below 0 on either axis is clamped to 0 on that axis, and out_err is set with the result.
- R7: A start coordinate above the area size minus 8 is clamped to the area size minus 8, and out_err is set. A start position inside the legal range gives out_err low. out_err is never high while out_valid is low.
- R8: When a write and a read hit the same sample in the same cycle, the read returns the value held before the write. The next read returns the new value.
- R9: After reset, out_valid, out_err and out_blk are all zero. While out_valid is low, out_blk keeps its last value.
- R10: Output sample (i, j), for column i and row j, occupies out_blk bits [(j*8+i)*SMP_W +: SMP_W] and holds the area sample at (x0+i, y0+j).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one sample this cycle |
| wr_x | input | $clog2(AREA_W) | Write column |
| wr_y | input | $clog2(AREA_H) | Write row |
| wr_data | input | SMP_W | Sample to write |
| rd_en | input | 1 | Request one 8x8 block |
| org_x | input | $clog2(AREA_W) | Block origin column |
| org_y | input | $clog2(AREA_H) | Block origin row |
| mv_x | input | MV_W | Signed horizontal motion vector |
| mv_y | input | MV_W | Signed vertical motion vector |
| out_valid | output | 1 | out_blk holds a new block |
| out_err | output | 1 | Start position was clamped |
| out_blk | output | 64*SMP_W | 8x8 block in raster order |

## Verification
A write and a read can fall in the same cycle, and can even target the same sample. The bench provokes this by writing a fresh value to a sample inside the window that is being read in that same cycle. It then reads the same window again in the next cycle. The reference model keeps the order fixed: it computes the read from its memory before it applies the write. So the first result must carry the old sample and the second must carry the new one, and the full 64-sample output is compared on every clock.

// File: rtl/ref_blk_fetch_pkg.sv
package ref_blk_fetch_pkg;
  localparam int GRID   = 8;
  localparam int NBANK  = GRID * GRID;
  localparam int OFS_W  = $clog2(GRID);
  localparam int BSEL_W = $clog2(NBANK);
endpackage

// File: rtl/fetch_axis_clamp.sv
module fetch_axis_clamp #(
  parameter int SPAN = 64,
  parameter int MV_W = 8
) (
  input  logic [$clog2(SPAN)-1:0] org,
  input  logic [MV_W-1:0]         mv,
  output logic [$clog2(SPAN)-1:0] pos,
  output logic                    clip
);
  localparam int CW   = $clog2(SPAN);
  localparam int PW   = ((CW > MV_W) ? CW : MV_W) + 2;
  localparam int MAXP = SPAN - ref_blk_fetch_pkg::GRID;

  logic [PW-1:0] sum;
  logic          neg;
  logic          over;

  always_comb begin
    sum  = PW'(org) + {{(PW-MV_W){mv[MV_W-1]}}, mv};
    neg  = sum[PW-1];
    over = !neg && (sum > PW'(MAXP));
    clip = neg | over;
    if (neg)       pos = '0;
    else if (over) pos = CW'(MAXP);
    else           pos = sum[CW-1:0];
  end
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
  import ref_blk_fetch_pkg::*;
#(
  parameter int AREA_W = 64,
  parameter int AREA_H = 64,
  parameter int MV_W   = 8,
  parameter int AW     = 6
) (
  input  logic [$clog2(AREA_W)-1:0] org_x,
  input  logic [$clog2(AREA_H)-1:0] org_y,
  input  logic [MV_W-1:0]           mv_x,
  input  logic [MV_W-1:0]           mv_y,
  output logic [NBANK*AW-1:0]       bank_addr,
  output logic [OFS_W-1:0]          ofs_x,
  output logic [OFS_W-1:0]          ofs_y,
  output logic                      clip
);
  localparam int XW  = $clog2(AREA_W);
  localparam int YW  = $clog2(AREA_H);
  localparam int TXW = XW - OFS_W;
  localparam int TYW = YW - OFS_W;
  localparam int TPR = AREA_W / GRID;

  logic [XW-1:0]  pos_x;
  logic [YW-1:0]  pos_y;
  logic           clip_x;
  logic           clip_y;
  logic [TXW-1:0] tcol [GRID];
  logic [TYW-1:0] trow [GRID];

  fetch_axis_clamp #(.SPAN(AREA_W), .MV_W(MV_W)) u_clamp_x (
    .org(org_x), .mv(mv_x), .pos(pos_x), .clip(clip_x));
  fetch_axis_clamp #(.SPAN(AREA_H), .MV_W(MV_W)) u_clamp_y (
    .org(org_y), .mv(mv_y), .pos(pos_y), .clip(clip_y));

  assign ofs_x = pos_x[OFS_W-1:0];
  assign ofs_y = pos_y[OFS_W-1:0];
  assign clip  = clip_x | clip_y;

  // a bank left of (above) the offset lies in the next tile column (row)
  for (genvar k = 0; k < GRID; k++) begin : g_tile
    assign tcol[k] = pos_x[XW-1:OFS_W] + TXW'(OFS_W'(k) < ofs_x);
    assign trow[k] = pos_y[YW-1:OFS_W] + TYW'(OFS_W'(k) < ofs_y);
  end

  for (genvar r = 0; r < GRID; r++) begin : g_row
    for (genvar c = 0; c < GRID; c++) begin : g_col
      assign bank_addr[(r*GRID+c)*AW +: AW] =
        AW'(trow[r]) * AW'(TPR) + AW'(tcol[c]);
    end
  end
endmodule

// File: rtl/fetch_bank_array.sv
module fetch_bank_array
  import ref_blk_fetch_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int SMP_W = 8
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [BSEL_W-1:0]      wr_bank,
  input  logic [AW-1:0]          wr_addr,
  input  logic [SMP_W-1:0]       wr_data,
  input  logic                   rd_en,
  input  logic [NBANK*AW-1:0]    rd_addr,
  output logic [NBANK*SMP_W-1:0] rd_data
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [SMP_W-1:0] mem [DEPTH];
    logic [SMP_W-1:0] q;

    // read and write share the edge: a read sees the value before the write
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == BSEL_W'(b))) mem[wr_addr] <= wr_data;
      if (rd_en) q <= mem[rd_addr[b*AW +: AW]];
    end

    assign rd_data[b*SMP_W +: SMP_W] = q;
  end
endmodule

// File: rtl/fetch_rotator.sv
module fetch_rotator
  import ref_blk_fetch_pkg::*;
#(
  parameter int SMP_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_err,
  input  logic [OFS_W-1:0]       ofs_x,
  input  logic [OFS_W-1:0]       ofs_y,
  input  logic [NBANK*SMP_W-1:0] bank_data,
  output logic                   out_valid,
  output logic                   out_err,
  output logic [NBANK*SMP_W-1:0] out_blk
);
  logic [SMP_W-1:0]       bank_arr [NBANK];
  logic [NBANK*SMP_W-1:0] rot;
  logic [NBANK*SMP_W-1:0] blk_nxt;
  logic                   err_nxt;

  for (genvar b = 0; b < NBANK; b++) begin : g_unpack
    assign bank_arr[b] = bank_data[b*SMP_W +: SMP_W];
  end

  for (genvar j = 0; j < GRID; j++) begin : g_j
    for (genvar i = 0; i < GRID; i++) begin : g_i
      logic [OFS_W-1:0] bc;
      logic [OFS_W-1:0] br;
      assign bc = ofs_x + OFS_W'(i);
      assign br = ofs_y + OFS_W'(j);
      assign rot[(j*GRID+i)*SMP_W +: SMP_W] = bank_arr[{br, bc}];
    end
  end

  always_comb begin
    blk_nxt = in_valid ? rot : out_blk;
    err_nxt = in_valid & in_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_blk   <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= err_nxt;
      out_blk   <= blk_nxt;
    end
  end
endmodule

// File: rtl/ref_blk_fetch.sv
module ref_blk_fetch
  import ref_blk_fetch_pkg::*;
#(
  parameter int AREA_W = 64,
  parameter int AREA_H = 64,
  parameter int SMP_W  = 8,
  parameter int MV_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(AREA_W)-1:0] wr_x,
  input  logic [$clog2(AREA_H)-1:0] wr_y,
  input  logic [SMP_W-1:0]          wr_data,
  input  logic                      rd_en,
  input  logic [$clog2(AREA_W)-1:0] org_x,
  input  logic [$clog2(AREA_H)-1:0] org_y,
  input  logic [MV_W-1:0]           mv_x,
  input  logic [MV_W-1:0]           mv_y,
  output logic                      out_valid,
  output logic                      out_err,
  output logic [NBANK*SMP_W-1:0]    out_blk
);
  localparam int XW    = $clog2(AREA_W);
  localparam int YW    = $clog2(AREA_H);
  localparam int TPR   = AREA_W / GRID;
  localparam int DEPTH = TPR * (AREA_H / GRID);
  localparam int AW    = $clog2(DEPTH);

  logic [NBANK*AW-1:0]    rd_addr;
  logic [OFS_W-1:0]       ofs_x;
  logic [OFS_W-1:0]       ofs_y;
  logic                   clip;
  logic [BSEL_W-1:0]      wr_bank;
  logic [AW-1:0]          wr_addr;
  logic [NBANK*SMP_W-1:0] bank_q;

  logic                   s1_valid;
  logic                   s1_err;
  logic [OFS_W-1:0]       s1_ofs_x;
  logic [OFS_W-1:0]       s1_ofs_y;
  logic                   s1_err_nxt;
  logic [OFS_W-1:0]       s1_ofs_x_nxt;
  logic [OFS_W-1:0]       s1_ofs_y_nxt;

  assign wr_bank = {wr_y[OFS_W-1:0], wr_x[OFS_W-1:0]};
  assign wr_addr = AW'(wr_y[YW-1:OFS_W]) * AW'(TPR) + AW'(wr_x[XW-1:OFS_W]);

  fetch_addr_gen #(.AREA_W(AREA_W), .AREA_H(AREA_H), .MV_W(MV_W), .AW(AW)) u_addr (
    .org_x(org_x), .org_y(org_y), .mv_x(mv_x), .mv_y(mv_y),
    .bank_addr(rd_addr), .ofs_x(ofs_x), .ofs_y(ofs_y), .clip(clip));

  fetch_bank_array #(.DEPTH(DEPTH), .AW(AW), .SMP_W(SMP_W)) u_banks (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(bank_q));

  // side information travels one stage alongside the memory read
  always_comb begin
    s1_err_nxt   = rd_en ? clip  : s1_err;
    s1_ofs_x_nxt = rd_en ? ofs_x : s1_ofs_x;
    s1_ofs_y_nxt = rd_en ? ofs_y : s1_ofs_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
      s1_ofs_x <= '0;
      s1_ofs_y <= '0;
    end else begin
      s1_valid <= rd_en;
      s1_err   <= s1_err_nxt;
      s1_ofs_x <= s1_ofs_x_nxt;
      s1_ofs_y <= s1_ofs_y_nxt;
    end
  end

  fetch_rotator #(.SMP_W(SMP_W)) u_rot (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_err(s1_err),
    .ofs_x(s1_ofs_x), .ofs_y(s1_ofs_y), .bank_data(bank_q),
    .out_valid(out_valid), .out_err(out_err), .out_blk(out_blk));
endmodule

// File: rtl/ref_blk_fetch_chk.sv
module ref_blk_fetch_chk #(
  parameter int AREA_W = 64,
  parameter int AREA_H = 64,
  parameter int SMP_W  = 8,
  parameter int MV_W   = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rd_en,
  input logic [$clog2(AREA_W)-1:0] org_x,
  input logic [$clog2(AREA_H)-1:0] org_y,
  input logic [MV_W-1:0]           mv_x,
  input logic [MV_W-1:0]           mv_y,
  input logic                      out_valid,
  input logic                      out_err,
  input logic [64*SMP_W-1:0]       out_blk
);
  localparam int XW = $clog2(AREA_W);
  localparam int YW = $clog2(AREA_H);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ##1 out_valid);

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ##1 !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_blk));

  p_err_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  p_inrange_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mv_x == '0 && mv_y == '0 &&
     org_x <= XW'(AREA_W - 8) && org_y <= YW'(AREA_H - 8)) |=> ##1 !out_err);
endmodule

bind ref_blk_fetch ref_blk_fetch_chk #(
  .AREA_W(AREA_W), .AREA_H(AREA_H), .SMP_W(SMP_W), .MV_W(MV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .org_x(org_x), .org_y(org_y),
  .mv_x(mv_x), .mv_y(mv_y), .out_valid(out_valid), .out_err(out_err),
  .out_blk(out_blk));

// File: tb/ref_blk_fetch_test.sv
module ref_blk_fetch_test;
  localparam int W  = 64;
  localparam int H  = 64;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_x = '0;
  logic [5:0] wr_y = '0;
  logic [SW-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [5:0] org_x = '0;
  logic [5:0] org_y = '0;
  logic [7:0] mv_x = '0;
  logic [7:0] mv_y = '0;
  logic out_valid;
  logic out_err;
  logic [64*SW-1:0] out_blk;

  int checks = 0;
  int fails  = 0;
  string tag = "R9";

  always #2 clk = ~clk;

  ref_blk_fetch uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
    .wr_data(wr_data), .rd_en(rd_en), .org_x(org_x), .org_y(org_y),
    .mv_x(mv_x), .mv_y(mv_y), .out_valid(out_valid), .out_err(out_err),
    .out_blk(out_blk));

  // behavioural reference: area memory plus a two-deep result queue
  int mem [W*H];
  int a_blk [64];
  int b_blk [64];
  int e_blk [64];
  bit a_v, b_v, a_e, b_e;
  string a_t = "R9";
  string b_t = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      a_v = 0; b_v = 0; a_e = 0; b_e = 0;
      foreach (e_blk[k]) e_blk[k] = 0;
    end else begin
      b_v = a_v; b_e = a_e; b_blk = a_blk; b_t = a_t;
      if (b_v) e_blk = b_blk;
      a_v = rd_en;
      if (rd_en) begin
        int x0, y0;
        x0 = int'(org_x) + int'($signed(mv_x));
        y0 = int'(org_y) + int'($signed(mv_y));
        a_e = 0;
        if (x0 < 0) begin x0 = 0; a_e = 1; end
        if (x0 > W-8) begin x0 = W-8; a_e = 1; end
        if (y0 < 0) begin y0 = 0; a_e = 1; end
        if (y0 > H-8) begin y0 = H-8; a_e = 1; end
        for (int j = 0; j < 8; j++)
          for (int i = 0; i < 8; i++)
            a_blk[j*8+i] = mem[(y0+j)*W + x0+i];
        a_t = tag;
      end
      if (wr_en) mem[int'(wr_y)*W + int'(wr_x)] = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (out_valid !== b_v) begin
        fails++;
        $display("FAIL %s out_valid act=%0d exp=%0d", b_t, out_valid, b_v);
      end
      checks++;
      if (out_err !== (b_v & b_e)) begin
        fails++;
        $display("FAIL %s out_err act=%0d exp=%0d", b_t, out_err, b_v & b_e);
      end
      checks++;
      begin
        int bad;
        bad = -1;
        for (int k = 63; k >= 0; k--)
          if (int'(out_blk[k*SW +: SW]) !== e_blk[k]) bad = k;
        if (bad >= 0) begin
          fails++;
          $display("FAIL %s sample %0d act=%0d exp=%0d", b_t, bad,
                   out_blk[bad*SW +: SW], e_blk[bad]);
        end
      end
    end
  end

  task automatic step(bit we, int wx, int wy, int wd,
                      bit re, int ox, int oy, int mx, int my);
    @(posedge clk);
    #1;
    wr_en = we; wr_x = 6'(wx); wr_y = 6'(wy); wr_data = SW'(wd);
    rd_en = re; org_x = 6'(ox); org_y = 6'(oy); mv_x = 8'(mx); mv_y = 8'(my);
  endtask

  task automatic rd(int ox, int oy, int mx, int my);
    step(0, 0, 0, 0, 1, ox, oy, mx, my);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state, compared by the per-cycle monitor
    tag = "R9";
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1: fill the whole area
    tag = "R1";
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        step(1, x, y, (x*5 + y*17 + (x>>3)*3 + 1) & 255, 0, 0, 0, 0, 0);
    // R2 and R10: aligned windows
    tag = "R2 R10";
    rd(0, 0, 0, 0);
    rd(8, 16, 0, 0);
    rd(48, 56, 8, 0);
    rd(56, 56, 0, 0);
    // R3: unaligned windows spanning up to four tiles
    tag = "R3";
    rd(20, 20, 3, -6);
    rd(5, 9, 0, 0);
    rd(33, 1, 2, 6);
    rd(56, 56, -1, -7);
    // R5: back-to-back reads in random order
    tag = "R5";
    for (int n = 0; n < 300; n++)
      rd($urandom_range(0, 56), $urandom_range(0, 56), 0, 0);
    for (int n = 0; n < 100; n++)
      rd($urandom_range(0, 63), $urandom_range(0, 63),
         int'($urandom_range(0, 40)) - 20, int'($urandom_range(0, 40)) - 20);
    // R6: clamping below zero
    tag = "R6";
    rd(2, 2, -10, -3);
    rd(10, 0, 0, -1);
    rd(0, 0, -128, 0);
    // R7: clamping past the far edge, and in-range reads without flag
    tag = "R7";
    rd(60, 50, 10, 0);
    rd(40, 63, 0, 127);
    rd(57, 0, 0, 0);
    rd(56, 56, 0, 0);
    // R8: write and read of the same sample in one cycle
    tag = "R8";
    step(1, 12, 13, 8'hAA, 1, 10, 10, 0, 0);
    rd(10, 10, 0, 0);
    step(1, 3, 3, 8'h55, 1, 1, 2, 0, 0);
    step(1, 4, 4, 8'h0F, 1, 1, 2, 0, 0);
    rd(1, 2, 0, 0);
    // R9: gaps with writes only; output must hold
    tag = "R9";
    step(1, 20, 20, 8'h11, 0, 0, 0, 0, 0);
    step(1, 21, 20, 8'h22, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(18, 18, 0, 0);
    step(1, 19, 18, 8'h33, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule